// File: doc/BRIEF.md
# SDRAM Command Interval Sequencer

This block sits between a memory requester and the command pins of a single-data-rate SDRAM. It places one command at a time on the bus. After each command it holds a minimum gap, measured in SDRAM clocks, before it accepts the next one. Throughout that gap the bus carries NOP. The gaps come from a small configuration register that holds one interval per command class. When the system clock changes, software can retune those intervals instead of relying on values fixed at design time.

A requester presents an operation together with `req_valid`. The block takes it on the clock edge where `req_ready` is high. The block also drives the clock-enable pin: it lowers the pin when entering self refresh and raises it again on exit. A configuration write that arrives while a gap is running is parked. It is applied at the first idle edge, so the interval settings never change in the middle of an access.

Top module: `sdr_gap_seq`

## Requirements
- R1: After reset, `sd_cmd` is NOP (4'b0111), `sd_cke` is 1 and `req_ready` is 1. The intervals reset to long Mode Register Set gap selected, refresh code 7 and access code 7.
- R2: `req_ready` is high only when the gap of the previous command has fully elapsed. A request with `req_valid` high on an edge where `req_ready` is high is accepted, and its command appears on `sd_cmd` in the next cycle. A gap of N clocks means the next command can appear N cycles after the previous one at the earliest.
- R3: In every cycle where no command is being issued, including every cycle inside a gap, `sd_cmd` is NOP (4'b0111). The bits are ordered {cs_n, ras_n, cas_n, we_n}.
- R4: Operation code 0 (Mode Register Set) drives 4'b0000. Its gap is 2 clocks when the long-gap bit is 1 and 1 clock when it is 0.
- R5: Operation code 1 (Auto Refresh) drives 4'b0001 with a gap of refresh code + 1 clocks, so codes 0..7 give 1..8 clocks.
- R6: Operation code 4 (access) drives the requester's `req_cmd` value with a gap of access code + 1 clocks.
- R7: Operation code 2 (self-refresh entry) drives 4'b0001 with `sd_cke` low in the same cycle, followed by a gap of refresh code + 1 clocks. `sd_cke` stays low until an exit is accepted.
- R8: While in self refresh, every request other than exit is ignored: `sd_cmd` stays NOP and `sd_cke` stays low.
- R9: Operation code 3 (self-refresh exit) raises `sd_cke` while driving NOP, then enforces refresh code + 1 clocks before the next command. An exit request outside self refresh is ignored.
- R10: A configuration write on an idle edge (where `req_ready` is high) takes effect for commands accepted from the next edge on. A write on a busy edge is held and applied at the first idle edge. If a second write arrives while one is held, the later write replaces the held one.
- R11: When a command is accepted on the same edge that a configuration update is applied, that command uses the previous intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation: 0 MRS, 1 refresh, 2 self-refresh entry, 3 exit, 4 access |
| req_cmd | input | 4 | Command bits used for an access |
| req_ready | output | 1 | Previous gap has elapsed |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mrd_long | input | 1 | Selects the 2-clock Mode Register Set gap |
| cfg_rc_code | input | 3 | Refresh and self-refresh interval code |
| cfg_acc_code | input | 3 | Access interval code |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sd_cke | output | 1 | SDRAM clock enable |

## Verification
Two functions can fall on the same edge: accepting a command and applying a parked configuration update. The bench provokes this by writing new intervals while a long refresh gap is still running, then issuing a refresh as soon as `req_ready` rises. That refresh must keep the old gap, and only the refresh after it may use the new one. A behavioural model in the bench, with its own pending-write slot, is compared on every clock, including through a long random mix of operations and configuration writes that lands on this collision many times.

// File: rtl/sdr_gap_pkg.sv
package sdr_gap_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [2:0] {
    OP_MRS      = 3'd0,
    OP_AREF     = 3'd1,
    OP_SR_ENTER = 3'd2,
    OP_SR_EXIT  = 3'd3,
    OP_ACCESS   = 3'd4
  } sdr_op_e;

  localparam logic [CMD_W-1:0] CMD_NOP  = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_AREF = 4'b0001;
  localparam logic [CMD_W-1:0] CMD_MRS  = 4'b0000;
endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             idle
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1)); // R2
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> idle); // R2
endmodule

// File: rtl/sdr_gap_cfg.sv
module sdr_gap_cfg #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              wr,
  input  logic              wr_mrd_long,
  input  logic [CODE_W-1:0] wr_rc,
  input  logic [CODE_W-1:0] wr_acc,
  output logic              mrd_long,
  output logic [CODE_W-1:0] rc_code,
  output logic [CODE_W-1:0] acc_code
);
  logic              pend;
  logic              pend_mrd;
  logic [CODE_W-1:0] pend_rc;
  logic [CODE_W-1:0] pend_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      mrd_long <= 1'b1;
      rc_code  <= '1;
      acc_code <= '1;
      pend     <= 1'b0;
      pend_mrd <= 1'b0;
      pend_rc  <= '0;
      pend_acc <= '0;
    end else if (idle) begin
      if (wr) begin
        mrd_long <= wr_mrd_long;
        rc_code  <= wr_rc;
        acc_code <= wr_acc;
      end else if (pend) begin
        mrd_long <= pend_mrd;
        rc_code  <= pend_rc;
        acc_code <= pend_acc;
      end
      pend <= 1'b0;
    end else if (wr) begin
      pend     <= 1'b1;
      pend_mrd <= wr_mrd_long;
      pend_rc  <= wr_rc;
      pend_acc <= wr_acc;
    end
  end

  AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable({mrd_long, rc_code, acc_code})); // R10
  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (idle && pend) |=> !pend); // R10
endmodule

// File: rtl/sdr_gap_seq.sv
module sdr_gap_seq
  import sdr_gap_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [CMD_W-1:0]  req_cmd,
  output logic              req_ready,
  input  logic              cfg_we,
  input  logic              cfg_mrd_long,
  input  logic [CODE_W-1:0] cfg_rc_code,
  input  logic [CODE_W-1:0] cfg_acc_code,
  output logic [CMD_W-1:0]  sd_cmd,
  output logic              sd_cke
);
  localparam int CNT_W = CODE_W;

  logic              idle;
  logic              mrd_long;
  logic [CODE_W-1:0] rc_code;
  logic [CODE_W-1:0] acc_code;
  logic              legal;
  logic              accept;
  logic [CNT_W-1:0]  load_val;
  logic [CMD_W-1:0]  cmd_d;
  logic [CMD_W-1:0]  cmd_q;
  logic              cke_q;

  sdr_gap_cfg #(.CODE_W(CODE_W)) u_cfg (
    .clk(clk), .rst(rst), .idle(idle),
    .wr(cfg_we), .wr_mrd_long(cfg_mrd_long), .wr_rc(cfg_rc_code), .wr_acc(cfg_acc_code),
    .mrd_long(mrd_long), .rc_code(rc_code), .acc_code(acc_code)
  );

  // legality depends on the self-refresh state held in the clock-enable register
  always_comb begin
    legal    = 1'b0;
    cmd_d    = CMD_NOP;
    load_val = rc_code;
    case (req_op)
      OP_MRS: begin
        legal    = cke_q;
        cmd_d    = CMD_MRS;
        load_val = {{(CNT_W-1){1'b0}}, mrd_long};
      end
      OP_AREF, OP_SR_ENTER: begin
        legal = cke_q;
        cmd_d = CMD_AREF;
      end
      OP_SR_EXIT: legal = !cke_q;
      OP_ACCESS: begin
        legal    = cke_q;
        cmd_d    = req_cmd;
        load_val = acc_code;
      end
      default: legal = 1'b0;
    endcase
  end

  assign accept = req_valid && idle && legal;

  sdr_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(accept), .load_val(load_val), .idle(idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_NOP;
      cke_q <= 1'b1;
    end else begin
      cmd_q <= accept ? cmd_d : CMD_NOP;
      if (accept && req_op == OP_SR_ENTER)     cke_q <= 1'b0;
      else if (accept && req_op == OP_SR_EXIT) cke_q <= 1'b1;
    end
  end

  assign sd_cmd    = cmd_q;
  assign sd_cke    = cke_q;
  assign req_ready = idle;

  AST_NOP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> (sd_cmd == CMD_NOP)); // R3
  AST_CKE_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!sd_cke && !(req_valid && req_ready && req_op == OP_SR_EXIT)) |=> !sd_cke); // R7
  AST_ENTRY_DROPS_CKE: assert property (@(posedge clk) disable iff (rst)
    (sd_cke && req_valid && req_ready && req_op == OP_SR_ENTER) |=> (!sd_cke && sd_cmd == CMD_AREF)); // R7
  AST_SR_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (!sd_cke && req_valid && req_op != OP_SR_EXIT) |=> (sd_cmd == CMD_NOP)); // R8
  AST_EXIT_NOP: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_cke) |-> (sd_cmd == CMD_NOP)); // R9
endmodule

// File: tb/sdr_gap_seq_tb.sv
module sdr_gap_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [3:0] req_cmd = 4'b0111;
  logic       req_ready;
  logic       cfg_we = 1'b0;
  logic       cfg_mrd_long = 1'b0;
  logic [2:0] cfg_rc_code = 3'd0;
  logic [2:0] cfg_acc_code = 3'd0;
  logic [3:0] sd_cmd;
  logic       sd_cke;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sdr_gap_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_cmd(req_cmd),
    .req_ready(req_ready), .cfg_we(cfg_we), .cfg_mrd_long(cfg_mrd_long),
    .cfg_rc_code(cfg_rc_code), .cfg_acc_code(cfg_acc_code), .sd_cmd(sd_cmd), .sd_cke(sd_cke)
  );

  // behavioural reference
  int m_wait, m_rc, m_acc, p_rc, p_acc;
  bit m_cke, m_mrd, p_on, p_mrd;
  logic [3:0] m_cmd;

  always @(posedge clk) begin
    int gap;
    bit ok;
    bit busy;
    if (rst) begin
      m_wait = 0; m_cke = 1; m_cmd = 4'b0111;
      m_mrd = 1; m_rc = 7; m_acc = 7; p_on = 0; p_mrd = 0; p_rc = 0; p_acc = 0;
      model_on = 1'b1;
    end else begin
      busy = (m_wait != 0);
      ok = 0; gap = 1; m_cmd = 4'b0111;
      if (req_valid && !busy) begin
        if (req_op == 3'd0 && m_cke)      begin ok = 1; m_cmd = 4'b0000; gap = m_mrd ? 2 : 1; end
        else if (req_op == 3'd1 && m_cke) begin ok = 1; m_cmd = 4'b0001; gap = m_rc + 1; end
        else if (req_op == 3'd2 && m_cke) begin ok = 1; m_cmd = 4'b0001; gap = m_rc + 1; m_cke = 0; end
        else if (req_op == 3'd3 && !m_cke) begin ok = 1; gap = m_rc + 1; m_cke = 1; end
        else if (req_op == 3'd4 && m_cke) begin ok = 1; m_cmd = req_cmd; gap = m_acc + 1; end
      end
      if (ok) m_wait = gap - 1;
      else if (m_wait > 0) m_wait = m_wait - 1;
      if (!busy) begin
        if (cfg_we) begin m_mrd = cfg_mrd_long; m_rc = cfg_rc_code; m_acc = cfg_acc_code; end
        else if (p_on) begin m_mrd = p_mrd; m_rc = p_rc; m_acc = p_acc; end
        p_on = 0;
      end else if (cfg_we) begin
        p_on = 1; p_mrd = cfg_mrd_long; p_rc = cfg_rc_code; p_acc = cfg_acc_code;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !finished) begin
      checks++;
      if (sd_cmd !== m_cmd || sd_cke !== m_cke || req_ready !== (m_wait == 0)) begin
        errors++;
        $display("FAIL %s model: cmd=%b cke=%b rdy=%b expected cmd=%b cke=%b rdy=%b",
                 cur_req, sd_cmd, sd_cke, req_ready, m_cmd, m_cke, (m_wait == 0));
      end
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [3:0] c);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_cmd = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic gap_is(input int exp, input string tag);
    int n = 1;
    while (!req_ready) begin @(negedge clk); n++; end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic cfg_set(input bit m, input logic [2:0] rc, input logic [2:0] ac);
    cfg_we = 1'b1; cfg_mrd_long = m; cfg_rc_code = rc; cfg_acc_code = ac;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    chk(sd_cmd == 4'b0111 && sd_cke && req_ready, "R1 reset outputs", {sd_cmd, sd_cke, req_ready}, 6'b011111);
    issue(3'd1, 4'b0); gap_is(8, "R1 default refresh gap");
    issue(3'd0, 4'b0); gap_is(2, "R1 default mrs gap");
    cfg_set(1'b0, 3'd4, 3'd2);
    cur_req = "R4";
    issue(3'd0, 4'b0); chk(sd_cmd == 4'b0000, "R4 mrs code", sd_cmd, 0); gap_is(1, "R4 short mrs gap");
    cur_req = "R5";
    issue(3'd1, 4'b0); chk(sd_cmd == 4'b0001, "R5 refresh code", sd_cmd, 1); gap_is(5, "R5 refresh gap");
    cur_req = "R6";
    issue(3'd4, 4'b0011); chk(sd_cmd == 4'b0011, "R6 access code", sd_cmd, 3); gap_is(3, "R6 access gap");
    cfg_set(1'b1, 3'd4, 3'd2);
    cur_req = "R4";
    issue(3'd0, 4'b0); gap_is(2, "R4 long mrs gap");
    cur_req = "R10";
    issue(3'd1, 4'b0);
    chk(sd_cmd == 4'b0001, "R3 issue cycle", sd_cmd, 1);
    cfg_set(1'b1, 3'd1, 3'd2);
    cfg_set(1'b1, 3'd0, 3'd2);
    chk(sd_cmd == 4'b0111, "R3 nop in gap", sd_cmd, 7);
    cur_req = "R11";
    issue(3'd1, 4'b0); gap_is(5, "R11 collision keeps old gap");
    cur_req = "R10";
    issue(3'd1, 4'b0); gap_is(1, "R10 held write applied");
    cfg_set(1'b1, 3'd2, 3'd2);
    cur_req = "R7";
    issue(3'd2, 4'b0);
    chk(sd_cmd == 4'b0001 && !sd_cke, "R7 entry cmd with cke low", {sd_cmd, sd_cke}, 5'b00010);
    gap_is(3, "R7 entry gap");
    repeat (4) @(negedge clk);
    chk(!sd_cke, "R7 cke held low", sd_cke, 0);
    cur_req = "R8";
    issue(3'd0, 4'b0);
    chk(sd_cmd == 4'b0111 && !sd_cke, "R8 mrs ignored", {sd_cmd, sd_cke}, 5'b01110);
    issue(3'd4, 4'b0011);
    chk(sd_cmd == 4'b0111 && !sd_cke && req_ready, "R8 access ignored", {sd_cmd, sd_cke}, 5'b01110);
    cur_req = "R9";
    issue(3'd3, 4'b0);
    chk(sd_cmd == 4'b0111 && sd_cke, "R9 exit raises cke", {sd_cmd, sd_cke}, 5'b01111);
    gap_is(3, "R9 exit gap");
    issue(3'd3, 4'b0);
    chk(sd_cmd == 4'b0111 && sd_cke && req_ready, "R9 stray exit ignored", {sd_cmd, sd_cke, req_ready}, 6'b011111);
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      req_valid = ($urandom % 3) != 0;
      req_op = 3'($urandom % 5);
      req_cmd = 4'($urandom);
      cfg_we = ($urandom % 12) == 0;
      cfg_mrd_long = 1'($urandom);
      cfg_rc_code = 3'($urandom);
      cfg_acc_code = 3'($urandom);
      @(negedge clk);
    end
    req_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule